// File: doc/BRIEF.md
# Multi-Channel Ring Command Buffer

This block stores command words for several channels in one shared storage array. Each channel owns a contiguous slice of that array. The slice is bounded by a programmable first address and an inclusive last address. Each channel also has its own read and write pointers. A word pushed for a channel lands at that channel's write pointer, and a pop returns the word under its read pointer. Each pointer steps by one, and when it sits on the last address of the slice it returns to the first address.

A host can inspect the buffer through a debug inspection port without changing any state. The host loads an inspection control register with an enable, a channel number and an absolute array address. While the port is enabled, it returns the word stored at that address together with the selected channel's two pointers and empty flag. Loading the control register with the enable clear turns the port off. While the port is off, all of its outputs read zero.

Pushes and pops are single-cycle strobes that carry a channel number; there is no ready signal. Per-channel full and empty flags act as back-pressure, and a source is expected to look at them before it strobes. A push to a full channel or a pop from an empty one is dropped and recorded in a sticky per-channel error bit.

Top module: `cmd_ring_fifo`

## Requirements
- R1: After reset, channel c covers addresses c*(DEPTH/NUM_CH) to (c+1)*(DEPTH/NUM_CH)-1, both of its pointers equal that first address, every channel is empty and not full, all error bits are 0, pop_valid_o is 0 and the inspection port is disabled.
- R2: An accepted push writes push_data at the channel's write pointer and advances that pointer. An accepted pop drives pop_valid_o high on the next cycle with pop_data_o equal to the oldest stored word of that channel, so each channel returns its words in first-in first-out order. pop_valid_o is low in every cycle that does not follow an accepted pop.
- R3: A pointer equal to its channel's last address moves to the channel's first address on its next step; any other pointer moves up by one.
- R4: empty_o[c] is 1 exactly when channel c's read pointer equals its write pointer, and full_o[c] is 1 exactly when one step of the write pointer would make it equal the read pointer. A channel therefore holds at most (last - first) words.
- R5: A push to a full channel changes no pointer and no stored word, and sets err_ovf_o[c], which stays at 1 until the next setup write to that channel.
- R6: A pop from an empty channel changes no pointer, leaves pop_valid_o low on the next cycle, and sets err_unf_o[c], which stays at 1 until the next setup write to that channel.
- R7: A setup write (cfg_we with cfg_ch) loads the channel's first and last addresses, sets both of its pointers to the new first address, and clears both of its error bits. A push or pop to that same channel in the same cycle is dropped and raises no error.
- R8: A write with peek_we loads the enable, channel and address fields, and these take effect from the next cycle. While the port is enabled, peek_data_o is the word stored at that absolute address, peek_rd_ptr_o and peek_wr_ptr_o are the selected channel's pointers, and peek_empty_o is its empty flag. While the port is disabled, all four outputs are 0.
- R9: Inspection reads never move any pointer or alter any stored word.
- R10: A push, pop or setup write on one channel leaves the pointers, flags and error bits of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_ch | input | CH_W | Channel being set up |
| cfg_base | input | AW | New first address of the slice |
| cfg_limit | input | AW | New inclusive last address of the slice |
| push_en | input | 1 | Push strobe |
| push_ch | input | CH_W | Channel to push into |
| push_data | input | DATA_W | Word to store |
| pop_en | input | 1 | Pop strobe |
| pop_ch | input | CH_W | Channel to pop from |
| pop_valid_o | output | 1 | Popped word present, one cycle after an accepted pop |
| pop_data_o | output | DATA_W | Popped word |
| full_o | output | NUM_CH | Per-channel full flags |
| empty_o | output | NUM_CH | Per-channel empty flags |
| err_ovf_o | output | NUM_CH | Sticky push-while-full error bits |
| err_unf_o | output | NUM_CH | Sticky pop-while-empty error bits |
| peek_we | input | 1 | Inspection control write strobe |
| peek_en_i | input | 1 | Enable field of the inspection control |
| peek_ch_i | input | CH_W | Channel field of the inspection control |
| peek_addr_i | input | AW | Address field of the inspection control |
| peek_data_o | output | DATA_W | Word at the inspected address, 0 when disabled |
| peek_rd_ptr_o | output | AW | Read pointer of the inspected channel, 0 when disabled |
| peek_wr_ptr_o | output | AW | Write pointer of the inspected channel, 0 when disabled |
| peek_empty_o | output | 1 | Empty flag of the inspected channel, 0 when disabled |

## Verification
The assertions assume that every setup write has a first address no greater than its last address. Under that assumption the pointer range properties hold from reset onward. They also assume that the slices of different channels do not overlap, since overlapping slices would let one channel overwrite another channel's words. The random stimulus keeps every channel inside its own quarter of the array: it draws the first address within that quarter and the last address between the first address and the end of the quarter. Small slices that come out of this draw push the channels through full, empty and wrap often.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  localparam int DEF_NUM_CH = 4;
  localparam int DEF_DEPTH  = 64;
  localparam int DEF_DATA_W = 32;

  function automatic int unsigned ring_step(int unsigned p, int unsigned first,
                                            int unsigned last);
    return (p == last) ? first : p + 1;
  endfunction
endpackage

// File: rtl/cfifo_chan.sv
module cfifo_chan #(
  parameter int AW        = 6,
  parameter int RST_BASE  = 0,
  parameter int RST_LIMIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          setup_we,
  input  logic [AW-1:0] setup_base,
  input  logic [AW-1:0] setup_limit,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] base,
  output logic [AW-1:0] limit,
  output logic          empty,
  output logic          full,
  output logic          ovf_err,
  output logic          unf_err
);
  logic [AW-1:0] rd_next, wr_next;

  always_comb begin
    rd_next = AW'(cfifo_pkg::ring_step(int'(rd_ptr), int'(base), int'(limit)));
    wr_next = AW'(cfifo_pkg::ring_step(int'(wr_ptr), int'(base), int'(limit)));
  end

  assign empty   = (rd_ptr == wr_ptr);
  assign full    = (wr_next == rd_ptr);
  assign push_ok = push_req && !full && !setup_we;
  assign pop_ok  = pop_req && !empty && !setup_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= AW'(RST_BASE);
      limit   <= AW'(RST_LIMIT);
      rd_ptr  <= AW'(RST_BASE);
      wr_ptr  <= AW'(RST_BASE);
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else if (setup_we) begin
      base    <= setup_base;
      limit   <= setup_limit;
      rd_ptr  <= setup_base;
      wr_ptr  <= setup_base;
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_next;
      if (pop_ok)  rd_ptr <= rd_next;
      if (push_req && full) ovf_err <= 1'b1;
      if (pop_req && empty) unf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/cfifo_store.sv
module cfifo_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/cfifo_peek.sv
module cfifo_peek #(
  parameter int NUM_CH = 4,
  parameter int AW     = 6,
  parameter int DATA_W = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_we,
  input  logic                       ctl_en,
  input  logic [CH_W-1:0]            ctl_ch,
  input  logic [AW-1:0]              ctl_addr,
  input  logic [NUM_CH-1:0][AW-1:0]  rd_ptrs,
  input  logic [NUM_CH-1:0][AW-1:0]  wr_ptrs,
  input  logic [NUM_CH-1:0]          empties,
  output logic [AW-1:0]              mem_addr,
  input  logic [DATA_W-1:0]          mem_word,
  output logic [DATA_W-1:0]          data_o,
  output logic [AW-1:0]              rd_o,
  output logic [AW-1:0]              wr_o,
  output logic                       empty_o
);
  logic            en_q;
  logic [CH_W-1:0] ch_q;
  logic [AW-1:0]   addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ch_q   <= '0;
      addr_q <= '0;
    end else if (ctl_we) begin
      en_q   <= ctl_en;
      ch_q   <= ctl_ch;
      addr_q <= ctl_addr;
    end
  end

  assign mem_addr = addr_q;

  always_comb begin
    data_o  = '0;
    rd_o    = '0;
    wr_o    = '0;
    empty_o = 1'b0;
    if (en_q) begin
      data_o = mem_word;
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_q == CH_W'(i)) begin
          rd_o    = rd_ptrs[i];
          wr_o    = wr_ptrs[i];
          empty_o = empties[i];
        end
      end
    end
  end
endmodule

// File: rtl/cmd_ring_fifo.sv
module cmd_ring_fifo #(
  parameter int NUM_CH = cfifo_pkg::DEF_NUM_CH,
  parameter int DEPTH  = cfifo_pkg::DEF_DEPTH,
  parameter int DATA_W = cfifo_pkg::DEF_DATA_W,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW    = $clog2(DEPTH),
  localparam int SLICE = DEPTH / NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [AW-1:0]     cfg_base,
  input  logic [AW-1:0]     cfg_limit,
  input  logic              push_en,
  input  logic [CH_W-1:0]   push_ch,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_en,
  input  logic [CH_W-1:0]   pop_ch,
  output logic              pop_valid_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [NUM_CH-1:0] full_o,
  output logic [NUM_CH-1:0] empty_o,
  output logic [NUM_CH-1:0] err_ovf_o,
  output logic [NUM_CH-1:0] err_unf_o,
  input  logic              peek_we,
  input  logic              peek_en_i,
  input  logic [CH_W-1:0]   peek_ch_i,
  input  logic [AW-1:0]     peek_addr_i,
  output logic [DATA_W-1:0] peek_data_o,
  output logic [AW-1:0]     peek_rd_ptr_o,
  output logic [AW-1:0]     peek_wr_ptr_o,
  output logic              peek_empty_o
);
  logic [NUM_CH-1:0][AW-1:0] rd_ptr_q, wr_ptr_q, base_q, limit_q;
  logic [NUM_CH-1:0]         push_ok, pop_ok;
  logic [AW-1:0]             wr_addr, pop_addr, peek_addr;
  logic [DATA_W-1:0]         pop_word, peek_word;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_cfg, sel_push, sel_pop;
    assign sel_cfg  = cfg_we  && (cfg_ch  == CH_W'(c));
    assign sel_push = push_en && (push_ch == CH_W'(c));
    assign sel_pop  = pop_en  && (pop_ch  == CH_W'(c));

    cfifo_chan #(
      .AW        (AW),
      .RST_BASE  (c * SLICE),
      .RST_LIMIT (c * SLICE + SLICE - 1)
    ) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .setup_we    (sel_cfg),
      .setup_base  (cfg_base),
      .setup_limit (cfg_limit),
      .push_req    (sel_push),
      .pop_req     (sel_pop),
      .push_ok     (push_ok[c]),
      .pop_ok      (pop_ok[c]),
      .rd_ptr      (rd_ptr_q[c]),
      .wr_ptr      (wr_ptr_q[c]),
      .base        (base_q[c]),
      .limit       (limit_q[c]),
      .empty       (empty_o[c]),
      .full        (full_o[c]),
      .ovf_err     (err_ovf_o[c]),
      .unf_err     (err_unf_o[c])
    );
  end

  always_comb begin
    wr_addr  = '0;
    pop_addr = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (push_ok[i]) wr_addr  = wr_ptr_q[i];
      if (pop_ok[i])  pop_addr = rd_ptr_q[i];
    end
  end

  cfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .we      (|push_ok),
    .waddr   (wr_addr),
    .wdata   (push_data),
    .raddr_a (pop_addr),
    .rdata_a (pop_word),
    .raddr_b (peek_addr),
    .rdata_b (peek_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_valid_o <= 1'b0;
      pop_data_o  <= '0;
    end else begin
      pop_valid_o <= |pop_ok;
      if (|pop_ok) pop_data_o <= pop_word;
    end
  end

  cfifo_peek #(.NUM_CH(NUM_CH), .AW(AW), .DATA_W(DATA_W)) u_peek (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (peek_we),
    .ctl_en   (peek_en_i),
    .ctl_ch   (peek_ch_i),
    .ctl_addr (peek_addr_i),
    .rd_ptrs  (rd_ptr_q),
    .wr_ptrs  (wr_ptr_q),
    .empties  (empty_o),
    .mem_addr (peek_addr),
    .mem_word (peek_word),
    .data_o   (peek_data_o),
    .rd_o     (peek_rd_ptr_o),
    .wr_o     (peek_wr_ptr_o),
    .empty_o  (peek_empty_o)
  );
endmodule

// File: rtl/cfifo_chk.sv
module cfifo_chk #(
  parameter int NUM_CH = 4,
  parameter int AW     = 6,
  parameter int DATA_W = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_we,
  input logic [CH_W-1:0]           cfg_ch,
  input logic [AW-1:0]             cfg_base,
  input logic [AW-1:0]             cfg_limit,
  input logic                      push_en,
  input logic [CH_W-1:0]           push_ch,
  input logic                      pop_en,
  input logic [CH_W-1:0]           pop_ch,
  input logic                      pop_valid_o,
  input logic [NUM_CH-1:0]         full_o,
  input logic [NUM_CH-1:0]         empty_o,
  input logic [NUM_CH-1:0]         err_ovf_o,
  input logic [NUM_CH-1:0]         err_unf_o,
  input logic                      peek_we,
  input logic                      peek_en_i,
  input logic [DATA_W-1:0]         peek_data_o,
  input logic [AW-1:0]             peek_rd_ptr_o,
  input logic [AW-1:0]             peek_wr_ptr_o,
  input logic [NUM_CH-1:0][AW-1:0] rd_ptr_q,
  input logic [NUM_CH-1:0][AW-1:0] wr_ptr_q,
  input logic [NUM_CH-1:0][AW-1:0] base_q,
  input logic [NUM_CH-1:0][AW-1:0] limit_q
);
  AST_CFG_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> cfg_base <= cfg_limit); // R7

  AST_SETUP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> empty_o[$past(cfg_ch)]); // R7

  AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    push_en && full_o[push_ch] && !(cfg_we && cfg_ch == push_ch)
    |=> err_ovf_o[$past(push_ch)]); // R5

  AST_UNF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en && empty_o[pop_ch] && !(cfg_we && cfg_ch == pop_ch)
    |=> err_unf_o[$past(pop_ch)] && !pop_valid_o); // R6

  AST_POP_DELIVERS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en && !empty_o[pop_ch] && !(cfg_we && cfg_ch == pop_ch)
    |=> pop_valid_o); // R2

  AST_NO_SPURIOUS_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_en |=> !pop_valid_o); // R2

  AST_PEEK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    peek_we && !peek_en_i
    |=> peek_data_o == '0 && peek_rd_ptr_o == '0 && peek_wr_ptr_o == '0); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_PTR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr_q[c] >= base_q[c] && rd_ptr_q[c] <= limit_q[c] &&
      wr_ptr_q[c] >= base_q[c] && wr_ptr_q[c] <= limit_q[c]); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_ovf_o[c] && !(cfg_we && cfg_ch == CH_W'(c)) |=> err_ovf_o[c]); // R5

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_unf_o[c] && !(cfg_we && cfg_ch == CH_W'(c)) |=> err_unf_o[c]); // R6

    AST_FULL_NOT_EMPTY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      full_o[c] && empty_o[c] |-> base_q[c] == limit_q[c]); // R4
  end
endmodule

bind cmd_ring_fifo cfifo_chk #(.NUM_CH(NUM_CH), .AW(AW), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_cmd_ring_fifo.sv
module tb_cmd_ring_fifo;
  localparam int NCH = 4, DEP = 64, DW = 32, CW = 2, AW = 6, SL = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we, push_en, pop_en, peek_we, peek_en_i;
  logic [CW-1:0] cfg_ch, push_ch, pop_ch, peek_ch_i;
  logic [AW-1:0] cfg_base, cfg_limit, peek_addr_i;
  logic [DW-1:0] push_data;
  logic pop_valid_o, peek_empty_o;
  logic [DW-1:0] pop_data_o, peek_data_o;
  logic [NCH-1:0] full_o, empty_o, err_ovf_o, err_unf_o;
  logic [AW-1:0] peek_rd_ptr_o, peek_wr_ptr_o;

  always #5 clk = ~clk;

  cmd_ring_fifo dut (.*);

  int n_chk = 0, n_fail = 0;
  int m_base[NCH], m_lim[NCH], m_rd[NCH], m_wr[NCH];
  bit m_ovf[NCH], m_unf[NCH];
  logic [DW-1:0] m_mem[DEP];
  bit m_wrt[DEP];
  bit m_pv;
  logic [DW-1:0] m_pd;
  bit m_pen;
  int m_pch, m_paddr;

  function automatic int nxt(int c, int p);
    return (p == m_lim[c]) ? m_base[c] : p + 1;
  endfunction

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_ch = 0; cfg_base = 0; cfg_limit = 0;
    push_en = 0; push_ch = 0; push_data = 0;
    pop_en = 0; pop_ch = 0;
    peek_we = 0; peek_en_i = 0; peek_ch_i = 0; peek_addr_i = 0;
  endtask

  task automatic compare_all();
    chk(pop_valid_o == m_pv, "R2 pop_valid", 32'(pop_valid_o), 32'(m_pv));
    if (m_pv) chk(pop_data_o == m_pd, "R2 pop_data order", pop_data_o, m_pd);
    for (int c = 0; c < NCH; c++) begin
      chk(empty_o[c] == (m_rd[c] == m_wr[c]), "R4 empty", 32'(empty_o[c]),
          32'(m_rd[c] == m_wr[c]));
      chk(full_o[c] == (nxt(c, m_wr[c]) == m_rd[c]), "R4 full", 32'(full_o[c]),
          32'(nxt(c, m_wr[c]) == m_rd[c]));
      chk(err_ovf_o[c] == m_ovf[c], "R5 overflow sticky", 32'(err_ovf_o[c]), 32'(m_ovf[c]));
      chk(err_unf_o[c] == m_unf[c], "R6 underflow sticky", 32'(err_unf_o[c]), 32'(m_unf[c]));
    end
    if (m_pen) begin
      chk(peek_rd_ptr_o == AW'(m_rd[m_pch]), "R8 peek rd", 32'(peek_rd_ptr_o), 32'(m_rd[m_pch]));
      chk(peek_wr_ptr_o == AW'(m_wr[m_pch]), "R8 peek wr", 32'(peek_wr_ptr_o), 32'(m_wr[m_pch]));
      chk(peek_empty_o == (m_rd[m_pch] == m_wr[m_pch]), "R8 peek empty",
          32'(peek_empty_o), 32'(m_rd[m_pch] == m_wr[m_pch]));
      if (m_wrt[m_paddr])
        chk(peek_data_o == m_mem[m_paddr], "R8 peek data", peek_data_o, m_mem[m_paddr]);
    end else begin
      chk(peek_data_o == 0 && peek_rd_ptr_o == 0 && peek_wr_ptr_o == 0 && !peek_empty_o,
          "R8 peek disabled zero", peek_data_o, 0);
    end
  endtask

  // apply the driven inputs to the model, clock once, compare at the falling edge
  task automatic tick();
    int pc, oc, cc;
    bit push_go, pop_go, push_full, pop_empty;
    cc = int'(cfg_ch); pc = int'(push_ch); oc = int'(pop_ch);
    push_full = (nxt(pc, m_wr[pc]) == m_rd[pc]);
    pop_empty = (m_rd[oc] == m_wr[oc]);
    push_go = push_en && !(cfg_we && cc == pc);
    pop_go  = pop_en && !(cfg_we && cc == oc);
    m_pv = 0;
    if (push_go) begin
      if (push_full) m_ovf[pc] = 1;
      else begin
        m_mem[m_wr[pc]] = push_data; m_wrt[m_wr[pc]] = 1; m_wr[pc] = nxt(pc, m_wr[pc]);
      end
    end
    if (pop_go) begin
      if (pop_empty) m_unf[oc] = 1;
      else begin
        m_pv = 1; m_pd = m_mem[m_rd[oc]]; m_rd[oc] = nxt(oc, m_rd[oc]);
      end
    end
    if (cfg_we) begin
      m_base[cc] = int'(cfg_base); m_lim[cc] = int'(cfg_limit);
      m_rd[cc] = int'(cfg_base); m_wr[cc] = int'(cfg_base);
      m_ovf[cc] = 0; m_unf[cc] = 0;
    end
    if (peek_we) begin
      m_pen = peek_en_i; m_pch = int'(peek_ch_i); m_paddr = int'(peek_addr_i);
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic do_push(int c, logic [DW-1:0] d);
    push_en = 1; push_ch = CW'(c); push_data = d; tick();
  endtask
  task automatic do_pop(int c);
    pop_en = 1; pop_ch = CW'(c); tick();
  endtask
  task automatic do_peek(bit en, int c, int a);
    peek_we = 1; peek_en_i = en; peek_ch_i = CW'(c); peek_addr_i = AW'(a); tick();
  endtask
  task automatic do_cfg(int c, int b, int l);
    cfg_we = 1; cfg_ch = CW'(c); cfg_base = AW'(b); cfg_limit = AW'(l); tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    for (int c = 0; c < NCH; c++) begin
      m_base[c] = c * SL; m_lim[c] = c * SL + SL - 1; m_rd[c] = c * SL; m_wr[c] = c * SL;
      m_ovf[c] = 0; m_unf[c] = 0;
    end
    for (int a = 0; a < DEP; a++) m_wrt[a] = 0;
    m_pv = 0; m_pen = 0; m_pch = 0; m_paddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(!pop_valid_o && empty_o == '1 && full_o == '0, "R1 reset flags",
        {pop_valid_o, empty_o, full_o}, 32'h0f0);
    chk(err_ovf_o == 0 && err_unf_o == 0 && peek_data_o == 0, "R1 reset errors/peek",
        {err_ovf_o, err_unf_o}, 0);
    for (int c = 0; c < NCH; c++) begin
      do_peek(1, c, 0);
      chk(peek_rd_ptr_o == AW'(c * SL), "R1 reset region", 32'(peek_rd_ptr_o), c * SL);
    end

    // fill channel 0 to capacity, then overflow
    for (int i = 0; i < SL - 1; i++) do_push(0, 32'h100 + i);
    chk(full_o[0], "R4 full at capacity", 32'(full_o[0]), 1);
    do_push(0, 32'hdead);
    chk(err_ovf_o[0], "R5 overflow raised", 32'(err_ovf_o[0]), 1);

    // R10 other channel does not disturb channel 0
    do_peek(1, 0, 3);
    do_push(1, 32'h5555);
    chk(peek_rd_ptr_o == 0 && peek_wr_ptr_o == AW'(SL - 1), "R10 channel isolation",
        {peek_rd_ptr_o, peek_wr_ptr_o}, {6'd0, 6'd15});

    // R9 repeated inspection does not move pointers
    repeat (5) tick();
    chk(peek_wr_ptr_o == AW'(SL - 1) && peek_data_o == 32'h103, "R9 peek non-destructive",
        peek_data_o, 32'h103);
    for (int i = 0; i < SL - 1; i++) do_pop(0);
    do_pop(0);
    chk(err_unf_o[0] && !pop_valid_o, "R6 underflow raised", 32'(err_unf_o[0]), 1);

    // R7 setup resets pointers and errors; same-cycle push dropped silently
    do_push(0, 32'ha1);
    do_push(0, 32'ha2);
    cfg_we = 1; cfg_ch = 0; cfg_base = 4; cfg_limit = 6;
    push_en = 1; push_ch = 0; push_data = 32'hbad;
    tick();
    chk(peek_rd_ptr_o == 4 && peek_wr_ptr_o == 4 && err_ovf_o[0] == 0 && err_unf_o[0] == 0,
        "R7 setup reset", {peek_rd_ptr_o, peek_wr_ptr_o}, {6'd4, 6'd4});

    // R3 wrap inside a three-slot slice
    do_push(0, 32'hc0);
    do_push(0, 32'hc1);
    do_pop(0);
    do_push(0, 32'hc2);
    chk(peek_wr_ptr_o == 4 && peek_rd_ptr_o == 5, "R3 wrap to first address",
        {peek_rd_ptr_o, peek_wr_ptr_o}, {6'd5, 6'd4});
    do_pop(0);
    do_pop(0);
    chk(pop_data_o == 32'hc2, "R3 word after wrap", pop_data_o, 32'hc2);

    // R8 disabling clears the port
    do_peek(0, 2, 9);
    chk(peek_data_o == 0, "R8 disabled", peek_data_o, 0);

    // constrained random traffic, each channel confined to its own quarter
    for (int n = 0; n < 4000; n++) begin
      int r, c, b;
      r = int'($urandom % 100);
      if (r < 3) begin
        c = int'($urandom % NCH);
        b = c * SL + int'($urandom % SL);
        cfg_we = 1; cfg_ch = CW'(c); cfg_base = AW'(b);
        cfg_limit = AW'(b + int'($urandom % (c * SL + SL - b)));
      end
      if ($urandom % 100 < 50) begin
        push_en = 1; push_ch = CW'($urandom % NCH); push_data = $urandom;
      end
      if ($urandom % 100 < 40) begin
        pop_en = 1; pop_ch = CW'($urandom % NCH);
      end
      if ($urandom % 100 < 10) begin
        peek_we = 1; peek_en_i = ($urandom % 5) != 0;
        peek_ch_i = CW'($urandom % NCH); peek_addr_i = AW'($urandom % DEP);
      end
      tick();
    end

    summary();
    $finish;
  end
endmodule